// File: doc/BRIEF.md
# Chip Power State Sequencer

This block steps a chip through its power states: fully off, deep sleep, light sleep, a wakeup phase and full operation. It runs on the always-on slow clock. It drives the enables for the real-time-clock domain, the main power domain, the crystal oscillator and the PLL. It also drives a register-clear signal and one clock enable for each gated block. An enable pin forces the off state whenever it is low. A software request, qualified by a depth flag, puts the running chip into one of the two sleep depths. Four wake sources bring it back: MAC, host, RTC timer and external interrupt.

The states are OFF, DEEP, SLEEP, WAKE, ON and DRAIN, with these transitions:

- OFF→WAKE when the enable pin rises.
- WAKE→ON once the programmed settle count has elapsed.
- ON→DRAIN on a sleep request.
- DRAIN→SLEEP or DRAIN→DEEP according to the depth that was sampled with the request.
- SLEEP→WAKE on any wake source.
- DEEP→WAKE on an RTC or external wake only.
- Any state→OFF when the enable pin is low.

The DRAIN state closes every block clock while the oscillator and PLL are still running. Wake events that arrive during DRAIN are held, so they act as soon as the sleep state is reached.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: In the cycle after `chip_en` is sampled low, and after reset, `pwr_state` is 0 (OFF). In that state `regs_clr` is 1 and `rtc_en`, `main_pwr_en`, `xtal_en`, `pll_en` and `blk_clk_en` are all 0.
- R2: From OFF, `chip_en` sampled high moves `pwr_state` to 3 (WAKE).
- R3: In WAKE, `rtc_en`, `main_pwr_en`, `xtal_en` and `pll_en` are 1 and `blk_clk_en` is 0. WAKE lasts exactly `settle_cycles`+1 cycles and is then followed by 4 (ON). ON is entered only from WAKE.
- R4: In ON, all four supply enables are 1 and `blk_clk_en` equals `clk_ctrl` bit for bit. In every other state `blk_clk_en` is 0.
- R5: `sleep_req` sampled in ON moves to 5 (DRAIN) for exactly one cycle. DRAIN has `blk_clk_en` at 0 with `xtal_en` and `pll_en` still 1. DRAIN is followed by 2 (SLEEP) if `sleep_deep` was 0 with the request, or by 1 (DEEP) if it was 1.
- R6: In SLEEP, `rtc_en` and `main_pwr_en` are 1 and `xtal_en` and `pll_en` are 0. Any of `wake_mac`, `wake_host`, `wake_rtc`, `wake_ext` moves SLEEP to WAKE.
- R7: In DEEP, only `rtc_en` is 1. Only `wake_rtc` or `wake_ext` moves DEEP to WAKE. `wake_mac` and `wake_host` leave `pwr_state` at DEEP.
- R8: A wake pulse seen only during DRAIN is kept: after one cycle in the sleep state the machine moves to WAKE without any further event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| chip_en | input | 1 | Chip enable pin; low forces OFF |
| sleep_req | input | 1 | Request to leave ON for a sleep state |
| sleep_deep | input | 1 | Depth sampled with the request: 1 deep, 0 light |
| wake_mac | input | 1 | Wake event from the MAC |
| wake_host | input | 1 | Wake event from the host interface |
| wake_rtc | input | 1 | Wake event from the RTC timer |
| wake_ext | input | 1 | Wake event from an external interrupt |
| settle_cycles | input | CNT_W | Crystal settle time in slow-clock cycles, minus one |
| clk_ctrl | input | NBLK | Clock control register, one bit per block |
| rtc_en | output | 1 | RTC domain enable |
| main_pwr_en | output | 1 | Main power domain enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| regs_clr | output | 1 | Register clear, active high |
| blk_clk_en | output | NBLK | Per-block high-speed clock enable |
| pwr_state | output | 3 | Current state code (0 OFF, 1 DEEP, 2 SLEEP, 3 WAKE, 4 ON, 5 DRAIN) |

## Verification
The bench builds the block with NBLK=4 and CNT_W=4. These values make the widest settle count of 15 cheap enough to run in full next to the zero count, and give four block clocks for distinct bit patterns. A small counter width keeps every WAKE dwell short, so both sleep depths, every wake source, the pending-wake path and enable-pin drops from several states all fit into one run. A behavioural model predicts every output on every clock.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,
        PS_DEEP  = 3'd1,
        PS_SLEEP = 3'd2,
        PS_WAKE  = 3'd3,
        PS_ON    = 3'd4,
        PS_DRAIN = 3'd5
    } pwr_state_e;

    localparam int NWAKE   = 4;
    localparam int WK_MAC  = 0;
    localparam int WK_HOST = 1;
    localparam int WK_RTC  = 2;
    localparam int WK_EXT  = 3;

endpackage

// File: rtl/pwr_wake_hold.sv
module pwr_wake_hold #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            clear,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (clear) begin
            held <= '0;
        end else if (capture) begin
            held <= held | src;
        end
    end

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == limit);

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate #(
    parameter int NBLK = 4
) (
    input  logic            open_all,
    input  logic [NBLK-1:0] ctrl,
    output logic [NBLK-1:0] clk_en
);

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign clk_en[b] = open_all & ctrl[b];
    end

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       sleep_req,
    input  logic       sleep_deep,
    input  logic       wake_any,
    input  logic       wake_deep_ok,
    input  logic       settle_done,
    output pwr_state_e state,
    output logic       rtc_en,
    output logic       main_pwr_en,
    output logic       xtal_en,
    output logic       pll_en,
    output logic       regs_clr,
    output logic       clk_open
);

    pwr_state_e state_q, state_d;
    logic       deep_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!chip_en) begin
            state_d = PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF:   state_d = PS_WAKE;
                PS_WAKE:  if (settle_done) state_d = PS_ON;
                PS_ON:    if (sleep_req) state_d = PS_DRAIN;
                PS_DRAIN: state_d = deep_q ? PS_DEEP : PS_SLEEP;
                PS_SLEEP: if (wake_any) state_d = PS_WAKE;
                PS_DEEP:  if (wake_deep_ok) state_d = PS_WAKE;
                default:  state_d = PS_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
            deep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == PS_ON && sleep_req) begin
                deep_q <= sleep_deep;
            end
        end
    end

    // outputs per state
    always_comb begin
        rtc_en      = 1'b0;
        main_pwr_en = 1'b0;
        xtal_en     = 1'b0;
        pll_en      = 1'b0;
        regs_clr    = 1'b0;
        clk_open    = 1'b0;
        unique case (state_q)
            PS_OFF:   regs_clr = 1'b1;
            PS_DEEP:  rtc_en   = 1'b1;
            PS_SLEEP: begin
                rtc_en      = 1'b1;
                main_pwr_en = 1'b1;
            end
            PS_WAKE, PS_DRAIN: begin
                rtc_en      = 1'b1;
                main_pwr_en = 1'b1;
                xtal_en     = 1'b1;
                pll_en      = 1'b1;
            end
            PS_ON: begin
                rtc_en      = 1'b1;
                main_pwr_en = 1'b1;
                xtal_en     = 1'b1;
                pll_en      = 1'b1;
                clk_open    = 1'b1;
            end
            default:  regs_clr = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             sleep_req,
    input  logic             sleep_deep,
    input  logic             wake_mac,
    input  logic             wake_host,
    input  logic             wake_rtc,
    input  logic             wake_ext,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic [NBLK-1:0]  clk_ctrl,
    output logic             rtc_en,
    output logic             main_pwr_en,
    output logic             xtal_en,
    output logic             pll_en,
    output logic             regs_clr,
    output logic [NBLK-1:0]  blk_clk_en,
    output logic [2:0]       pwr_state
);

    pwr_state_e       state;
    logic [NWAKE-1:0] wk_src, wk_held, wk_all;
    logic             settle_done, clk_open;

    assign wk_src[WK_MAC]  = wake_mac;
    assign wk_src[WK_HOST] = wake_host;
    assign wk_src[WK_RTC]  = wake_rtc;
    assign wk_src[WK_EXT]  = wake_ext;
    assign wk_all          = wk_src | wk_held;

    pwr_wake_hold #(.NSRC(NWAKE)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state == PS_DRAIN),
        .clear   (state == PS_WAKE || state == PS_OFF),
        .src     (wk_src),
        .held    (wk_held)
    );

    pwr_settle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == PS_WAKE),
        .limit (settle_cycles),
        .done  (settle_done)
    );

    pwr_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_en      (chip_en),
        .sleep_req    (sleep_req),
        .sleep_deep   (sleep_deep),
        .wake_any     (|wk_all),
        .wake_deep_ok (wk_all[WK_RTC] | wk_all[WK_EXT]),
        .settle_done  (settle_done),
        .state        (state),
        .rtc_en       (rtc_en),
        .main_pwr_en  (main_pwr_en),
        .xtal_en      (xtal_en),
        .pll_en       (pll_en),
        .regs_clr     (regs_clr),
        .clk_open     (clk_open)
    );

    pwr_clk_gate #(.NBLK(NBLK)) i_gate (
        .open_all (clk_open),
        .ctrl     (clk_ctrl),
        .clk_en   (blk_clk_en)
    );

    assign pwr_state = state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int NBLK = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            chip_en,
    input logic            rtc_en,
    input logic            main_pwr_en,
    input logic            xtal_en,
    input logic            pll_en,
    input logic            regs_clr,
    input logic [NBLK-1:0] blk_clk_en,
    input logic [2:0]      pwr_state
);

    AST_PIN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (pwr_state == 3'd0) && regs_clr && !rtc_en && !main_pwr_en); // R1

    AST_ON_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_state == 3'd4) |-> $past(pwr_state) == 3'd3); // R3

    AST_GATED_OUTSIDE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd4) |-> (blk_clk_en == '0)); // R4

    AST_DRAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd5) |=> (pwr_state inside {3'd0, 3'd1, 3'd2})); // R5

    AST_CLK_BEFORE_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(xtal_en) && $past(chip_en)) |-> ($past(blk_clk_en) == '0)); // R5

    AST_SLEEP_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd2) |-> (rtc_en && main_pwr_en && !xtal_en && !pll_en)); // R6

    AST_DEEP_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd1) |-> (rtc_en && !main_pwr_en && !xtal_en && !pll_en)); // R7

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NBLK(NBLK)) i_pwr_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .rtc_en      (rtc_en),
    .main_pwr_en (main_pwr_en),
    .xtal_en     (xtal_en),
    .pll_en      (pll_en),
    .regs_clr    (regs_clr),
    .blk_clk_en  (blk_clk_en),
    .pwr_state   (pwr_state)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;

    localparam int NBLK  = 4;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chip_en = 1'b0, sleep_req = 1'b0, sleep_deep = 1'b0;
    logic             wake_mac = 1'b0, wake_host = 1'b0, wake_rtc = 1'b0, wake_ext = 1'b0;
    logic [CNT_W-1:0] settle_cycles = '0;
    logic [NBLK-1:0]  clk_ctrl = '0;
    logic             rtc_en, main_pwr_en, xtal_en, pll_en, regs_clr;
    logic [NBLK-1:0]  blk_clk_en;
    logic [2:0]       pwr_state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(.NBLK(NBLK), .CNT_W(CNT_W)) i_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sleep_req(sleep_req),
        .sleep_deep(sleep_deep), .wake_mac(wake_mac), .wake_host(wake_host),
        .wake_rtc(wake_rtc), .wake_ext(wake_ext), .settle_cycles(settle_cycles),
        .clk_ctrl(clk_ctrl), .rtc_en(rtc_en), .main_pwr_en(main_pwr_en),
        .xtal_en(xtal_en), .pll_en(pll_en), .regs_clr(regs_clr),
        .blk_clk_en(blk_clk_en), .pwr_state(pwr_state)
    );

    // behavioural reference: state codes 0 OFF 1 DEEP 2 SLEEP 3 WAKE 4 ON 5 DRAIN
    int m_st = 0;
    int m_wait = 0;
    bit m_deep = 0;
    bit m_pend_any = 0, m_pend_deep = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_wait = 0; m_deep = 0; m_pend_any = 0; m_pend_deep = 0;
        end else begin
            bit any_w, deep_w;
            int nxt;
            any_w  = wake_mac | wake_host | wake_rtc | wake_ext | m_pend_any;
            deep_w = wake_rtc | wake_ext | m_pend_deep;
            nxt = m_st;
            if (!chip_en) nxt = 0;
            else if (m_st == 0) nxt = 3;
            else if (m_st == 3) begin
                if (m_wait >= int'(settle_cycles)) nxt = 4;
            end
            else if (m_st == 4) begin
                if (sleep_req) begin nxt = 5; m_deep = sleep_deep; end
            end
            else if (m_st == 5) nxt = m_deep ? 1 : 2;
            else if (m_st == 2) begin if (any_w) nxt = 3; end
            else if (m_st == 1) begin if (deep_w) nxt = 3; end
            if (m_st == 5) begin
                m_pend_any  = m_pend_any | wake_mac | wake_host | wake_rtc | wake_ext;
                m_pend_deep = m_pend_deep | wake_rtc | wake_ext;
            end
            if (m_st == 3 || m_st == 0) begin
                m_pend_any = 0; m_pend_deep = 0;
            end
            if (m_st == 3 && nxt == 3) m_wait = m_wait + 1; else m_wait = 0;
            m_st = nxt;
        end
    end

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1: return "R7";
            2: return "R6";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [4:0] e_sup;
            logic [NBLK-1:0] e_clk;
            case (m_st)
                0: e_sup = 5'b00001;
                1: e_sup = 5'b10000;
                2: e_sup = 5'b11000;
                default: e_sup = 5'b11110;
            endcase
            e_clk = (m_st == 4) ? clk_ctrl : '0;
            checks++;
            if ({rtc_en, main_pwr_en, xtal_en, pll_en, regs_clr} !== e_sup ||
                blk_clk_en !== e_clk || pwr_state !== 3'(m_st)) begin
                errors++;
                $display("FAIL %s: state=%0d sup=%b clk=%b expected state=%0d sup=%b clk=%b",
                         tag_of(m_st), pwr_state,
                         {rtc_en, main_pwr_en, xtal_en, pll_en, regs_clr}, blk_clk_en,
                         m_st, e_sup, e_clk);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic expect_state(input logic [2:0] code, input string req);
        @(negedge clk); #1;
        checks++;
        if (pwr_state !== code) begin
            errors++;
            $display("FAIL %s: pwr_state=%0d expected=%0d", req, pwr_state, code);
        end
    endtask

    task automatic measure_wake(input int exp_len, input string req);
        int n = 0;
        @(negedge clk); #1;
        while (pwr_state == 3'd3 && n < 100) begin
            n++;
            @(negedge clk); #1;
        end
        checks++;
        if (n != exp_len || pwr_state !== 3'd4) begin
            errors++;
            $display("FAIL %s: wake_len=%0d end_state=%0d expected wake_len=%0d end_state=4",
                     req, n, pwr_state, exp_len);
        end
    endtask

    task automatic go_sleep(input bit deep);
        sleep_req = 1; sleep_deep = deep;
        tick();
        sleep_req = 0; sleep_deep = 0;
    endtask

    initial begin
        #20000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        expect_state(3'd0, "R1");                 // reset leaves OFF

        // R2 R3: power-up with settle 3 -> WAKE for 4 cycles
        settle_cycles = 4'd3; clk_ctrl = 4'b0101;
        tick(); chip_en = 1;
        tick();
        measure_wake(4, "R3");

        // R4: clock enables follow the control register
        clk_ctrl = 4'b1111; tick();
        clk_ctrl = 4'b0000; tick();
        clk_ctrl = 4'b1010; tick();
        expect_state(3'd4, "R4");

        // R5 R6: light sleep and host wake, zero settle
        settle_cycles = 4'd0;
        go_sleep(0);
        expect_state(3'd5, "R5");
        tick(); expect_state(3'd2, "R6");
        tick(); tick(); expect_state(3'd2, "R6");
        wake_host = 1; tick(); wake_host = 0;
        measure_wake(1, "R6");

        // R7: deep sleep ignores MAC and host, leaves on external wake
        go_sleep(1);
        tick(); expect_state(3'd1, "R5");
        wake_mac = 1; tick(); wake_mac = 0;
        wake_host = 1; tick(); wake_host = 0;
        tick(); expect_state(3'd1, "R7");
        wake_ext = 1; tick(); wake_ext = 0;
        measure_wake(1, "R7");

        // R7: deep sleep left by RTC timer, widest settle count
        settle_cycles = 4'd15;
        go_sleep(1);
        tick(); tick();
        wake_rtc = 1; tick(); wake_rtc = 0;
        measure_wake(16, "R7");

        // R8: wake pulse only during DRAIN is kept
        settle_cycles = 4'd1;
        go_sleep(0);
        wake_mac = 1; expect_state(3'd5, "R8");
        tick(); wake_mac = 0;
        expect_state(3'd2, "R8");
        tick(); expect_state(3'd3, "R8");
        tick(); tick(); expect_state(3'd4, "R8");

        // R8: MAC pulse during DRAIN does not wake deep sleep
        go_sleep(1);
        wake_mac = 1; tick(); wake_mac = 0;
        tick(); tick(); expect_state(3'd1, "R8");
        wake_rtc = 1; tick(); wake_rtc = 0;
        tick(); tick(); expect_state(3'd4, "R3");

        // R1: pin low from ON, from WAKE and from SLEEP
        clk_ctrl = 4'b1111;
        chip_en = 0; tick(); expect_state(3'd0, "R1");
        chip_en = 1; tick(); expect_state(3'd3, "R2");
        chip_en = 0; tick(); expect_state(3'd0, "R1");
        chip_en = 1; tick(); tick(); tick(); tick();
        go_sleep(0); tick();
        chip_en = 0; tick(); expect_state(3'd0, "R1");
        tick(); tick();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule